// File: doc/BRIEF.md
# Thermal Sensor Sample Scheduler

This block controls the sampling of one thermal-sensor channel. It asks an external converter for 12-bit conversions and averages a window of 1, 2, 4 or 8 raw results into one filtered sample. It stores that sample in a data register and raises a ready flag. A window starts in one of two ways. In single-shot mode, software sets an enable bit and the block clears that bit again once the result is stored. In periodic mode, a timer counts in units of 2^PRESC_W clocks.

Software programs the block through a word-addressed register port. The read result appears one cycle after the read strobe. Flags are cleared by writing ones to them. If a new result lands while the ready flag is still set, an overwrite flag records the lost sample. The level interrupt is high whenever any flag is set together with its enable. A channel-enable input gates the start of every window, and a window that has started always runs to completion.

Register words: address 0 is configuration, 1 is interval, 2 is filter code, 3 is data, 4 is interrupt status/enable. Unused addresses and unused bits read as zero.

Top module: `thsmp_sched`

## Requirements
- R1: After reset, all five registers read zero, and conv_req and irq are low.
- R2: Writing 1 to configuration bit 0 while ch_en is high starts exactly one window. Bit 0 reads back as 0 once that window's result is stored, and no further conversions follow.
- R3: While ch_en is low, no window starts and conv_req stays low. A pending single-shot request starts once ch_en rises.
- R4: The filter code in filter-register bits 1:0 selects 2^code conversions per window (code 0 = 1, 1 = 2, 2 = 4, 3 = 8). The stored 12-bit result (data register bits 11:0) is the sum of the window's results shifted right by the code, truncated.
- R5: With configuration bit 1 set, ch_en high and interval bits 31:16 equal to N > 0, conv_req stays low for exactly N·2^PRESC_W cycles between windows, when the converter acknowledges the cycle after each request.
- R6: An interval of zero stops periodic windows. No conversion is requested unless a single shot is pending.
- R7: Writes to the data register are ignored.
- R8: Interrupt-register bit 16 (ready) is set by every stored result. Writing 1 to bit 16 or to bit 17 clears that flag, and writing 0 to either bit leaves it unchanged.
- R9: Interrupt-register bit 17 (overwrite) is set when a result is stored while bit 16 is still set.
- R10: irq equals (bit16 AND bit0) OR (bit17 AND bit1) of the interrupt register, where bits 0 and 1 are the enables.
- R11: conv_acq carries configuration bits 15:8 and conv_hi_prio carries configuration bit 4.
- R12: conv_req stays high until conv_ack is seen, and each acknowledge delivers exactly one conversion result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 1 | Channel enable; gates window starts |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ack | input | 1 | Converter acknowledge with result |
| conv_data | input | DATA_W | Conversion result |
| conv_acq | output | 8 | Acquisition time setting for the converter |
| conv_hi_prio | output | 1 | Converter priority request |
| irq | output | 1 | Level interrupt |

## Verification
Single shots are run with all four filter codes. The values are chosen so that each one tells a correct divisor and truncation apart from rounding: a pair 1,2 gives 1, and three 4095s plus a 4094 give 4094. Eight full-scale results exercise the top of the accumulator. One run uses a slow converter, which separates holding the request from dropping it early. Periodic mode is measured by the exact gap between windows, and then with a zero interval. Back-to-back unread results with different enable settings separate the overwrite flag and the interrupt masking from the plain ready flag.

// File: rtl/thsmp_sched_pkg.sv
package thsmp_sched_pkg;
  localparam int REG_W   = 32;
  localparam int ACQ_W   = 8;
  localparam int FILT_W  = 2;

  localparam int CFG_SINGLE = 0;
  localparam int CFG_PERIOD = 1;
  localparam int CFG_PRIO   = 4;
  localparam int CFG_ACQ_LO = 8;
  localparam int ITV_LO     = 16;
  localparam int IE_RDY     = 0;
  localparam int IE_OVW     = 1;
  localparam int FL_RDY     = 16;
  localparam int FL_OVW     = 17;

  typedef enum logic [2:0] {
    RA_CFG  = 3'd0,
    RA_ITV  = 3'd1,
    RA_FILT = 3'd2,
    RA_DATA = 3'd3,
    RA_INT  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic [ACQ_W-1:0] acq;
    logic             prio;
    logic             period;
    logic             single;
  } cfg_t;
endpackage

// File: rtl/thsmp_itv_timer.sv
module thsmp_itv_timer #(
  parameter int PRESC_W = 16,
  parameter int ITV_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             busy,
  input  logic [ITV_W-1:0] itv,
  output logic             fire
);
  logic [PRESC_W-1:0] pre_q;
  logic [ITV_W-1:0]   unit_q;
  logic               pre_wrap;

  assign pre_wrap = &pre_q;
  assign fire     = armed && !busy && pre_wrap && (unit_q >= itv - ITV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !armed || busy || fire) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else begin
      pre_q <= pre_q + PRESC_W'(1);
      if (pre_wrap) unit_q <= unit_q + ITV_W'(1);
    end
  end
endmodule

// File: rtl/thsmp_avg_seq.sv
module thsmp_avg_seq
  import thsmp_sched_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FILT_W-1:0] k_in,
  input  logic              conv_ack,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_req,
  output logic              busy,
  output logic              store,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = (1 << FILT_W) - 1;
  localparam int ACC_W = DATA_W + CNT_W;

  typedef enum logic {S_IDLE, S_CONV} seq_state_e;

  seq_state_e        state_q;
  logic [ACC_W-1:0]  acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FILT_W-1:0] k_q;
  logic [CNT_W-1:0]  last_idx;
  logic [ACC_W-1:0]  sum;
  logic [ACC_W-1:0]  shifted;
  logic              accept;

  assign conv_req = (state_q == S_CONV);
  assign busy     = conv_req;
  assign accept   = conv_req && conv_ack;
  assign last_idx = ~({CNT_W{1'b1}} << k_q);
  assign sum      = acc_q + ACC_W'(conv_data);
  assign shifted  = sum >> k_q;
  assign result   = shifted[DATA_W-1:0];
  assign store    = accept && (cnt_q == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      acc_q   <= '0;
      cnt_q   <= '0;
      k_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_CONV;
          k_q     <= k_in;
          acc_q   <= '0;
          cnt_q   <= '0;
        end
        default: if (accept) begin
          acc_q <= sum;
          cnt_q <= cnt_q + CNT_W'(1);
          if (store) state_q <= S_IDLE;
        end
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_ack) |=> conv_req);
endmodule

// File: rtl/thsmp_reg_file.sv
module thsmp_reg_file
  import thsmp_sched_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 12,
  parameter int ITV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              store,
  input  logic [DATA_W-1:0] result,
  input  logic              single_done,
  output cfg_t              cfg,
  output logic [ITV_W-1:0]  itv,
  output logic [FILT_W-1:0] filt,
  output logic              irq
);
  cfg_t              cfg_q;
  logic [ITV_W-1:0]  itv_q;
  logic [FILT_W-1:0] filt_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        ie_q;
  logic              rdy_q, ovw_q, irq_q;
  logic [REG_W-1:0]  rdata_q;

  logic              wr_cfg, wr_itv, wr_filt, wr_int;
  logic              rdy_n, ovw_n;
  logic [1:0]        ie_n;

  assign wr_cfg  = wr && (addr == ADDR_W'(RA_CFG));
  assign wr_itv  = wr && (addr == ADDR_W'(RA_ITV));
  assign wr_filt = wr && (addr == ADDR_W'(RA_FILT));
  assign wr_int  = wr && (addr == ADDR_W'(RA_INT));

  always_comb begin
    rdy_n = store | (rdy_q & ~(wr_int & wdata[FL_RDY]));
    ovw_n = (store & rdy_q) | (ovw_q & ~(wr_int & wdata[FL_OVW]));
    ie_n  = wr_int ? wdata[IE_OVW:IE_RDY] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      itv_q  <= '0;
      filt_q <= '0;
      data_q <= '0;
      ie_q   <= '0;
      rdy_q  <= 1'b0;
      ovw_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_q.acq    <= wdata[CFG_ACQ_LO +: ACQ_W];
        cfg_q.prio   <= wdata[CFG_PRIO];
        cfg_q.period <= wdata[CFG_PERIOD];
        cfg_q.single <= wdata[CFG_SINGLE];
      end else if (single_done) begin
        cfg_q.single <= 1'b0;
      end
      if (wr_itv)  itv_q  <= wdata[ITV_LO +: ITV_W];
      if (wr_filt) filt_q <= wdata[FILT_W-1:0];
      if (store)   data_q <= result;
      ie_q  <= ie_n;
      rdy_q <= rdy_n;
      ovw_q <= ovw_n;
      irq_q <= (rdy_n & ie_n[0]) | (ovw_n & ie_n[1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= '0;
      case (addr)
        ADDR_W'(RA_CFG): begin
          rdata_q[CFG_ACQ_LO +: ACQ_W] <= cfg_q.acq;
          rdata_q[CFG_PRIO]            <= cfg_q.prio;
          rdata_q[CFG_PERIOD]          <= cfg_q.period;
          rdata_q[CFG_SINGLE]          <= cfg_q.single;
        end
        ADDR_W'(RA_ITV):  rdata_q[ITV_LO +: ITV_W] <= itv_q;
        ADDR_W'(RA_FILT): rdata_q[FILT_W-1:0]      <= filt_q;
        ADDR_W'(RA_DATA): rdata_q[DATA_W-1:0]      <= data_q;
        ADDR_W'(RA_INT): begin
          rdata_q[IE_OVW:IE_RDY] <= ie_q;
          rdata_q[FL_RDY]        <= rdy_q;
          rdata_q[FL_OVW]        <= ovw_q;
        end
        default: ;
      endcase
    end
  end

  assign cfg   = cfg_q;
  assign itv   = itv_q;
  assign filt  = filt_q;
  assign irq   = irq_q;
  assign rdata = rdata_q;

  // R9
  ovw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (store && rdy_q && !wr_int) |=> ovw_q);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    !(rdy_q || ovw_q) |-> !irq_q);
endmodule

// File: rtl/thsmp_sched.sv
module thsmp_sched
  import thsmp_sched_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 12,
  parameter int ITV_W   = 16,
  parameter int PRESC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              conv_req,
  input  logic              conv_ack,
  input  logic [DATA_W-1:0] conv_data,
  output logic [7:0]        conv_acq,
  output logic              conv_hi_prio,
  output logic              irq
);
  cfg_t              cfg;
  logic [ITV_W-1:0]  itv;
  logic [FILT_W-1:0] filt;
  logic              busy, store, fire, armed;
  logic              start_single, start, single_done;
  logic              win_single_q;
  logic [DATA_W-1:0] result;

  assign armed        = cfg.period && ch_en && (itv != '0);
  assign start_single = cfg.single && ch_en && !busy;
  assign start        = start_single || fire;
  assign single_done  = store && win_single_q;

  always_ff @(posedge clk) begin
    if (rst)        win_single_q <= 1'b0;
    else if (start) win_single_q <= start_single;
  end

  thsmp_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ITV_W(ITV_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .store(store), .result(result),
    .single_done(single_done), .cfg(cfg), .itv(itv), .filt(filt), .irq(irq)
  );

  thsmp_itv_timer #(.PRESC_W(PRESC_W), .ITV_W(ITV_W)) u_timer (
    .clk(clk), .rst(rst), .armed(armed), .busy(busy), .itv(itv), .fire(fire)
  );

  thsmp_avg_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .k_in(filt), .conv_ack(conv_ack),
    .conv_data(conv_data), .conv_req(conv_req), .busy(busy), .store(store),
    .result(result)
  );

  assign conv_acq     = cfg.acq;
  assign conv_hi_prio = cfg.prio;

  // R5
  fire_start_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> conv_req);

  // R6
  itv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((itv == '0) && !cfg.single && !busy) |=> !conv_req);
endmodule

// File: tb/thsmp_sched_tb.sv
module thsmp_sched_tb;
  localparam int PW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ch_en = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        conv_req, conv_ack = 1'b0;
  logic [11:0] conv_data = '0;
  logic [7:0]  conv_acq;
  logic        conv_hi_prio, irq;

  int n_chk = 0, n_err = 0;
  logic [11:0] adc_vals [0:7];
  int adc_ptr = 0, adc_lat = 0, adc_wait = 0, ack_count = 0;
  int viol = 0;
  logic prev_req = 1'b0, prev_ack = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  thsmp_sched #(.PRESC_W(PW)) u_dut (
    .clk(clk), .rst(rst), .ch_en(ch_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .conv_req(conv_req), .conv_ack(conv_ack), .conv_data(conv_data),
    .conv_acq(conv_acq), .conv_hi_prio(conv_hi_prio), .irq(irq)
  );

  // converter model
  initial forever begin
    @(posedge clk); #1;
    if (conv_ack) conv_ack = 1'b0;
    else if (conv_req && !rst) begin
      if (adc_wait >= adc_lat) begin
        conv_ack = 1'b1;
        conv_data = adc_vals[adc_ptr % 8];
        adc_ptr++; ack_count++; adc_wait = 0;
      end else adc_wait++;
    end
  end

  // request drop monitor
  initial forever begin
    @(negedge clk);
    if (!rst && prev_req && !conv_req && !prev_ack) viol++;
    prev_req = conv_req; prev_ack = conv_ack;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_window(string req);
    int t = 0;
    while (!conv_req && t < 2000) begin @(negedge clk); t++; end
    while (conv_req && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) begin
      n_err++; $display("FAIL %s window timeout actual 0 expected 1", req);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      do_read(3'(a), d);
      check("R1 reg reset", d, 32'h0);
    end
    check("R1 conv_req reset", 32'(conv_req), 32'h0);
    check("R1 irq reset", 32'(irq), 32'h0);
  endtask

  task automatic t_single(int code, int lat, string tag);
    logic [31:0] d;
    int n = 1 << code;
    int sum = 0;
    int c0;
    for (int i = 0; i < n; i++) sum += int'(adc_vals[i]);
    adc_ptr = 0; adc_lat = lat; ack_count = 0;
    do_write(3'd2, 32'(code));
    do_write(3'd4, 32'h3_0000);
    do_write(3'd0, 32'h1);
    wait_window(tag);
    check({tag, " R4 conversions per window"}, 32'(ack_count), 32'(n));
    do_read(3'd3, d);
    check({tag, " R4 averaged result"}, d, 32'((sum >> code) & 12'hFFF));
    do_read(3'd0, d);
    check({tag, " R2 single bit cleared"}, d & 32'h1, 32'h0);
    do_read(3'd4, d);
    check({tag, " R8 ready set"}, d & 32'h1_0000, 32'h1_0000);
    c0 = ack_count;
    repeat (30) @(negedge clk);
    check({tag, " R2 no extra conversion"}, 32'(ack_count), 32'(c0));
    do_write(3'd4, 32'h1_0000);
    do_read(3'd4, d);
    check({tag, " R8 ready cleared by w1c"}, d & 32'h1_0000, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    ch_en = 1'b0; ack_count = 0; adc_ptr = 0; adc_lat = 0;
    for (int i = 0; i < 8; i++) adc_vals[i] = 12'd321;
    do_write(3'd2, 32'h0);
    do_write(3'd0, 32'h1);
    repeat (30) @(negedge clk);
    check("R3 no request while ch_en low", 32'(ack_count), 32'h0);
    check("R3 conv_req low", 32'(conv_req), 32'h0);
    ch_en = 1'b1;
    wait_window("R3");
    do_read(3'd3, d);
    check("R3 result after ch_en rise", d, 32'd321);
    do_write(3'd4, 32'h3_0000);
  endtask

  task automatic t_data_ro();
    logic [31:0] d;
    do_write(3'd3, 32'h0000_0ABC);
    do_read(3'd3, d);
    check("R7 data write ignored", d, 32'd321);
  endtask

  task automatic t_ovw();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) adc_vals[i] = 12'd50 + 12'(i);
    adc_ptr = 0;
    do_write(3'd2, 32'h0);
    do_write(3'd4, 32'h3_0002);
    do_write(3'd0, 32'h1);
    wait_window("R9 first");
    do_read(3'd4, d);
    check("R9 no overwrite on first", d, 32'h1_0002);
    check("R10 irq masked ready", 32'(irq), 32'h0);
    do_write(3'd0, 32'h1);
    wait_window("R9 second");
    do_read(3'd4, d);
    check("R9 overwrite set", d, 32'h3_0002);
    check("R10 irq on overwrite", 32'(irq), 32'h1);
    do_write(3'd4, 32'h0_0002);
    do_read(3'd4, d);
    check("R8 zero write keeps flags", d, 32'h3_0002);
    do_write(3'd4, 32'h2_0001);
    do_read(3'd4, d);
    check("R8 clear overwrite only", d, 32'h1_0001);
    check("R10 irq on ready enable", 32'(irq), 32'h1);
    do_write(3'd4, 32'h1_0001);
    check("R10 irq low after clear", 32'(irq), 32'h0);
  endtask

  task automatic t_period();
    int gap;
    int t;
    int c0;
    for (int i = 0; i < 8; i++) adc_vals[i] = 12'd7;
    adc_lat = 0;
    do_write(3'd2, 32'h0);
    do_write(3'd1, 32'h0002_0000);
    do_write(3'd0, 32'h2);
    for (int w = 0; w < 2; w++) begin
      t = 0;
      while (!conv_req && t < 500) begin @(negedge clk); t++; end
      while (conv_req && t < 500) begin @(negedge clk); t++; end
      gap = 0;
      while (!conv_req && gap < 500) begin @(negedge clk); gap++; end
      check("R5 periodic gap", 32'(gap), 32'(2 << PW));
    end
    while (conv_req) @(negedge clk);
    do_write(3'd1, 32'h0);
    while (conv_req) @(negedge clk);
    repeat (3) @(negedge clk);
    c0 = ack_count;
    repeat (150) @(negedge clk);
    check("R6 zero interval stops", 32'(ack_count), 32'(c0));
    do_write(3'd0, 32'h0);
    do_write(3'd4, 32'h3_0000);
  endtask

  task automatic t_acq();
    logic [31:0] d;
    do_write(3'd0, 32'h5A10);
    check("R11 acq field", 32'(conv_acq), 32'h5A);
    check("R11 priority", 32'(conv_hi_prio), 32'h1);
    do_read(3'd0, d);
    check("R11 cfg readback", d, 32'h5A10);
    do_write(3'd0, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) adc_vals[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    ch_en = 1'b1;
    adc_vals[0] = 12'd100;
    t_single(0, 0, "code0");
    adc_vals[0] = 12'd1; adc_vals[1] = 12'd2;
    t_single(1, 0, "code1 truncation");
    adc_vals[0] = 12'd4095; adc_vals[1] = 12'd4095;
    adc_vals[2] = 12'd4095; adc_vals[3] = 12'd4094;
    t_single(2, 0, "code2");
    for (int i = 0; i < 8; i++) adc_vals[i] = 12'd4095;
    t_single(3, 0, "code3 full scale");
    for (int i = 0; i < 8; i++) adc_vals[i] = 12'(100 * i + 3);
    t_single(2, 3, "R12 slow converter");
    check("R12 request held until ack", 32'(viol), 32'h0);
    t_gate();
    t_data_ro();
    t_ovw();
    t_period();
    t_acq();
    check("R12 request held overall", 32'(viol), 32'h0);
    finish_run();
  end
endmodule